// File: doc/BRIEF.md
# Segmented Flash Erase and Program Controller

This block sits between a CPU bus and an on-chip nonvolatile array, modelled here as byte storage. The array has two regions. The main region spans 0xF000 to 0xFFFF in eight 512-byte segments. The information region spans 0x1000 to 0x10FF in two 128-byte segments. Software selects an operation by writing a control register. It then starts the operation with a write to the array: a dummy write for an erase, or a data write for a byte program. An internal timing generator runs the operation from a divided clock. It holds `busy` high until the operation completes, and software takes no further part.

While an operation runs, every read from the array returns the word 0x3FFF. A CPU that fetches code from the array therefore sees a jump-to-self and spins until the operation ends. A control-register write during an operation is dropped and raises a sticky access-violation flag. The power-up-clear input clears all control state and aborts any running operation.

Top module: `flash_seg_ctrl`

## Requirements
- R1: While `puc` is high at a clock edge, the following all clear at that edge: the mode field, the program-enable bit, the violation flag and `busy`. A control-register read then returns 0x0000.
- R2: The address decode works as follows.
  - Main segments are numbered 0 to 7 from the top. Segment 0 is 0xFE00–0xFFFF and segment 7 is 0xF000–0xF1FF.
  - Information segment A is 0x1080–0x10FF and segment B is 0x1000–0x107F.
  - The control register is at 0x0128. It reads as {12'b0, violation (bit 3), program enable (bit 2), mode (bits 1:0)}.
  - Any other address reads 0x0000.
- R3: When idle, a read of array address a returns, in the same cycle, {byte(a|1), byte(a&~1)}.
- R4: With mode 01, a write to any address in the array erases only the segment that holds that address, setting every byte to 0xFF.
- R5: A dummy write to any array address erases as follows.
  - With mode 10, it erases all eight main segments and leaves both information segments unchanged.
  - With mode 11, it erases all ten segments.
- R6: With mode 00 and program enable set, a write stores old AND `bus_wdata` into the addressed byte.
- R7: Timing of an operation:
  - `busy` rises in the cycle after the starting write.
  - It stays high for exactly ERASE_CYCLES×CLK_DIV cycles for an erase, or PROG_CYCLES×CLK_DIV cycles for a program.
  - The array content changes at the edge where `busy` falls.
  - A completed erase returns the mode field to 00.
- R8: While `busy` is high, every read of an array address returns 0x3FFF.
- R9: The violation flag behaves as follows.
  - A control-register write while `busy` is high leaves mode and program enable unchanged and sets the flag.
  - The flag stays set until an idle control-register write with bit 3 at 0.
  - An idle write with bit 3 at 1 leaves the flag as it was.
- R10: Some array writes have no effect on `busy` or on the content:
  - any array write while `busy` is high;
  - an array write when idle with mode 00 and program enable clear.
- R11: Asserting `puc` during an operation aborts it, and the array content stays as it was before the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also source of the divided timing clock |
| puc | input | 1 | Power-up-clear reset, active high, synchronous |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data (control fields or program byte) |
| bus_rdata | output | 16 | Combinational read word |
| busy | output | 1 | Operation in progress |
| acc_viol | output | 1 | Sticky access-violation flag |

## Verification
Each wrong internal state shows at the ports within a known number of cycles.

- **Wrong segment decode or erase mask.** This shows as a wrong word on the first read after the erase completes. The bench therefore reads neighbouring segments and both regions after each erase mode.
- **Divider or tick-count error.** This shifts the falling edge of `busy`, which the bench compares on every cycle against its reference model.
- **Stale mode or lost violation state.** This appears on the next control-register read, which the bench performs right after each operation and after each illegal write.

// File: rtl/flash_seg_pkg.sv
package flash_seg_pkg;

   typedef enum logic [1:0] {
      MD_PROG = 2'b00,
      MD_SEG  = 2'b01,
      MD_MAIN = 2'b10,
      MD_ALL  = 2'b11
   } mode_e;

   localparam logic [15:0] SPIN_WORD = 16'h3FFF;

endpackage

// File: rtl/flash_seg_decode.sv
module flash_seg_decode #(
   parameter int MAIN_BASE      = 32'hF000,
   parameter int MAIN_SEGS      = 8,
   parameter int MAIN_SEG_BYTES = 512,
   parameter int INFO_BASE      = 32'h1000,
   parameter int INFO_SEGS      = 2,
   parameter int INFO_SEG_BYTES = 128,
   parameter int CTRL_ADDR      = 32'h0128,
   parameter int SEGW           = 4,
   parameter int OFFW           = 9
) (
   input  logic [15:0]     addr,
   output logic            is_ctrl,
   output logic            is_arr,
   output logic [SEGW-1:0] bank,
   output logic [OFFW-1:0] boff
);

   localparam int MAIN_SIZE = MAIN_SEGS * MAIN_SEG_BYTES;
   localparam int INFO_SIZE = INFO_SEGS * INFO_SEG_BYTES;

   logic [31:0] aw, m_off, i_off;
   logic        in_main, in_info;

   always_comb begin
      aw      = {16'h0000, addr};
      m_off   = aw - 32'(MAIN_BASE);
      i_off   = aw - 32'(INFO_BASE);
      in_main = (aw >= 32'(MAIN_BASE)) && (aw < 32'(MAIN_BASE + MAIN_SIZE));
      in_info = (aw >= 32'(INFO_BASE)) && (aw < 32'(INFO_BASE + INFO_SIZE));
      is_ctrl = (aw == 32'(CTRL_ADDR));
      is_arr  = in_main || in_info;
      bank    = '0;
      boff    = '0;
      if (in_main) begin
         bank = SEGW'(32'(MAIN_SEGS - 1) - m_off / 32'(MAIN_SEG_BYTES));
         boff = OFFW'(m_off % 32'(MAIN_SEG_BYTES));
      end else if (in_info) begin
         bank = SEGW'(32'(MAIN_SEGS + INFO_SEGS - 1) - i_off / 32'(INFO_SEG_BYTES));
         boff = OFFW'(i_off % 32'(INFO_SEG_BYTES));
      end
   end

endmodule

// File: rtl/flash_seg_timer.sv
module flash_seg_timer #(
   parameter int CLK_DIV      = 3,
   parameter int ERASE_CYCLES = 4800,
   parameter int PROG_CYCLES  = 35
) (
   input  logic clk,
   input  logic puc,
   input  logic start,
   input  logic start_prog,
   output logic busy,
   output logic done
);

   localparam int MAXT = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
   localparam int TW   = $clog2(MAXT + 1);

   logic          busy_q;
   logic          tick;
   logic [TW-1:0] left_q;

   generate
      if (CLK_DIV > 1) begin : g_div
         localparam int DW = $clog2(CLK_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (puc || start || !busy_q) div_q <= '0;
            else if (div_q == DW'(CLK_DIV - 1)) div_q <= '0;
            else div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DW'(CLK_DIV - 1));
      end else begin : g_nodiv
         assign tick = 1'b1;
      end
   endgenerate

   assign done = busy_q && tick && (left_q == TW'(1));
   assign busy = busy_q;

   always_ff @(posedge clk) begin
      if (puc) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         left_q <= start_prog ? TW'(PROG_CYCLES) : TW'(ERASE_CYCLES);
      end else if (busy_q && tick) begin
         if (left_q == TW'(1)) busy_q <= 1'b0;
         left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/flash_seg_array.sv
module flash_seg_array #(
   parameter int MAIN_SEGS      = 8,
   parameter int MAIN_SEG_BYTES = 512,
   parameter int INFO_SEGS      = 2,
   parameter int INFO_SEG_BYTES = 128,
   parameter int SEGW           = 4,
   parameter int OFFW           = 9
) (
   input  logic                           clk,
   input  logic [MAIN_SEGS+INFO_SEGS-1:0] erase_mask,
   input  logic                           prog_we,
   input  logic [SEGW-1:0]                prog_bank,
   input  logic [OFFW-1:0]                prog_off,
   input  logic [7:0]                     prog_data,
   input  logic [SEGW-1:0]                rd_bank,
   input  logic [OFFW-2:0]                rd_off,
   output logic [15:0]                    rd_word
);

   localparam int NSEG = MAIN_SEGS + INFO_SEGS;

   logic [15:0] words [NSEG];

   generate
      for (genvar b = 0; b < NSEG; b++) begin : g_bank
         localparam int DEPTH = (b < MAIN_SEGS) ? MAIN_SEG_BYTES : INFO_SEG_BYTES;
         localparam int AB    = $clog2(DEPTH);
         logic [7:0] mem [DEPTH];
         logic       hit;
         assign hit = prog_we && (prog_bank == SEGW'(b));
         always_ff @(posedge clk) begin
            if (erase_mask[b]) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            end else if (hit) begin
               mem[prog_off[AB-1:0]] <= mem[prog_off[AB-1:0]] & prog_data;
            end
         end
         assign words[b] = {mem[{rd_off[AB-2:0], 1'b1}], mem[{rd_off[AB-2:0], 1'b0}]};
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int b = 0; b < NSEG; b++) begin
         if (rd_bank == SEGW'(b)) rd_word = words[b];
      end
   end

endmodule

// File: rtl/flash_seg_ctrl.sv
module flash_seg_ctrl
   import flash_seg_pkg::*;
#(
   parameter int MAIN_BASE      = 32'hF000,
   parameter int MAIN_SEGS      = 8,
   parameter int MAIN_SEG_BYTES = 512,
   parameter int INFO_BASE      = 32'h1000,
   parameter int INFO_SEGS      = 2,
   parameter int INFO_SEG_BYTES = 128,
   parameter int CTRL_ADDR      = 32'h0128,
   parameter int CLK_DIV        = 3,
   parameter int ERASE_CYCLES   = 4800,
   parameter int PROG_CYCLES    = 35
) (
   input  logic        clk,
   input  logic        puc,
   input  logic        bus_req,
   input  logic        bus_we,
   input  logic [15:0] bus_addr,
   input  logic [7:0]  bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        busy,
   output logic        acc_viol
);

   localparam int NSEG     = MAIN_SEGS + INFO_SEGS;
   localparam int SEGW     = $clog2(NSEG);
   localparam int MAXB     = (MAIN_SEG_BYTES > INFO_SEG_BYTES) ? MAIN_SEG_BYTES : INFO_SEG_BYTES;
   localparam int OFFW     = $clog2(MAXB);
   localparam int MAIN_END = MAIN_BASE + MAIN_SEGS * MAIN_SEG_BYTES;
   localparam int INFO_END = INFO_BASE + INFO_SEGS * INFO_SEG_BYTES;

   generate
      if ((MAIN_SEG_BYTES & (MAIN_SEG_BYTES - 1)) != 0 || MAIN_SEG_BYTES < 4) begin : g_err_mseg
         $error("main segment size must be a power of two of at least 4");
      end
      if ((INFO_SEG_BYTES & (INFO_SEG_BYTES - 1)) != 0 || INFO_SEG_BYTES < 4) begin : g_err_iseg
         $error("information segment size must be a power of two of at least 4");
      end
      if (MAIN_END > 65536 || INFO_END > 65536) begin : g_err_span
         $error("array regions exceed the 16-bit address space");
      end
      if (!(INFO_END <= MAIN_BASE || MAIN_END <= INFO_BASE)) begin : g_err_ovl
         $error("main and information regions overlap");
      end
      if ((CTRL_ADDR >= MAIN_BASE && CTRL_ADDR < MAIN_END) ||
          (CTRL_ADDR >= INFO_BASE && CTRL_ADDR < INFO_END)) begin : g_err_ctrl
         $error("control register address falls inside the array");
      end
      if (ERASE_CYCLES < 1 || PROG_CYCLES < 1 || CLK_DIV < 1) begin : g_err_time
         $error("cycle counts and divider must be at least 1");
      end
   endgenerate

   logic            is_ctrl, is_arr;
   logic [SEGW-1:0] bank;
   logic [OFFW-1:0] boff;

   flash_seg_decode #(
      .MAIN_BASE(MAIN_BASE), .MAIN_SEGS(MAIN_SEGS), .MAIN_SEG_BYTES(MAIN_SEG_BYTES),
      .INFO_BASE(INFO_BASE), .INFO_SEGS(INFO_SEGS), .INFO_SEG_BYTES(INFO_SEG_BYTES),
      .CTRL_ADDR(CTRL_ADDR), .SEGW(SEGW), .OFFW(OFFW)
   ) i_decode (
      .addr(bus_addr), .is_ctrl(is_ctrl), .is_arr(is_arr), .bank(bank), .boff(boff)
   );

   mode_e           mode_q;
   logic            prog_q, av_q;
   logic            wr, ctrl_wr, arr_wr, start, start_prog, done, erase_done;
   logic [NSEG-1:0] mask_sel, op_mask, erase_mask;
   logic            op_prog;
   logic [SEGW-1:0] op_bank;
   logic [OFFW-1:0] op_off;
   logic [7:0]      op_data;
   logic [15:0]     rd_word;

   assign wr         = bus_req && bus_we;
   assign ctrl_wr    = wr && is_ctrl;
   assign arr_wr     = wr && is_arr && !busy;
   assign start_prog = arr_wr && (mode_q == MD_PROG) && prog_q;
   assign start      = start_prog || (arr_wr && (mode_q != MD_PROG));
   assign erase_done = done && !op_prog;

   always_comb begin
      case (mode_q)
         MD_SEG:  mask_sel = NSEG'(1) << bank;
         MD_MAIN: mask_sel = {{INFO_SEGS{1'b0}}, {MAIN_SEGS{1'b1}}};
         MD_ALL:  mask_sel = {NSEG{1'b1}};
         default: mask_sel = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (puc) begin
         mode_q <= MD_PROG;
         prog_q <= 1'b0;
      end else if (ctrl_wr && !busy) begin
         mode_q <= mode_e'(bus_wdata[1:0]);
         prog_q <= bus_wdata[2];
      end else if (erase_done) begin
         mode_q <= MD_PROG;
      end
   end

   always_ff @(posedge clk) begin
      if (puc) av_q <= 1'b0;
      else if (ctrl_wr) av_q <= busy ? 1'b1 : (av_q & bus_wdata[3]);
   end

   always_ff @(posedge clk) begin
      if (puc) begin
         op_mask <= '0;
         op_prog <= 1'b0;
         op_bank <= '0;
         op_off  <= '0;
         op_data <= '0;
      end else if (start) begin
         op_mask <= start_prog ? '0 : mask_sel;
         op_prog <= start_prog;
         op_bank <= bank;
         op_off  <= boff;
         op_data <= bus_wdata;
      end
   end

   flash_seg_timer #(
      .CLK_DIV(CLK_DIV), .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
   ) i_timer (
      .clk(clk), .puc(puc), .start(start), .start_prog(start_prog), .busy(busy), .done(done)
   );

   assign erase_mask = erase_done ? op_mask : '0;

   flash_seg_array #(
      .MAIN_SEGS(MAIN_SEGS), .MAIN_SEG_BYTES(MAIN_SEG_BYTES),
      .INFO_SEGS(INFO_SEGS), .INFO_SEG_BYTES(INFO_SEG_BYTES),
      .SEGW(SEGW), .OFFW(OFFW)
   ) i_array (
      .clk(clk), .erase_mask(erase_mask), .prog_we(done && op_prog),
      .prog_bank(op_bank), .prog_off(op_off), .prog_data(op_data),
      .rd_bank(bank), .rd_off(boff[OFFW-1:1]), .rd_word(rd_word)
   );

   always_comb begin
      if (is_ctrl)     bus_rdata = {12'h000, av_q, prog_q, mode_q};
      else if (is_arr) bus_rdata = busy ? SPIN_WORD : rd_word;
      else             bus_rdata = 16'h0000;
   end

   assign acc_viol = av_q;

endmodule

// File: rtl/flash_seg_chk.sv
module flash_seg_chk (
   input logic        clk,
   input logic        puc,
   input logic        bus_req,
   input logic        bus_we,
   input logic        is_ctrl,
   input logic        is_arr,
   input logic [1:0]  mode,
   input logic        prog_en,
   input logic [15:0] bus_rdata,
   input logic        busy,
   input logic        acc_viol
);

   AST_RST_CLEAR: assert property (@(posedge clk) puc |=> (!busy && !acc_viol && mode == 2'b00 && !prog_en)); // R1

   AST_BUSY_WORD: assert property (@(posedge clk) disable iff (puc)
      (busy && is_arr) |-> (bus_rdata == 16'h3FFF)); // R8

   AST_START_CAUSE: assert property (@(posedge clk) disable iff (puc)
      $rose(busy) |-> $past(bus_req && bus_we && is_arr)); // R7

   AST_VIOL_SET: assert property (@(posedge clk) disable iff (puc)
      (bus_req && bus_we && is_ctrl && busy) |=> acc_viol); // R9

   AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (puc)
      (bus_req && bus_we && is_ctrl && busy) |=> ($stable(prog_en) && ($stable(mode) || mode == 2'b00))); // R9

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (puc)
      (acc_viol && !(bus_req && bus_we && is_ctrl)) |=> acc_viol); // R9

   AST_NO_OP_START: assert property (@(posedge clk) disable iff (puc)
      (!busy && bus_req && bus_we && is_arr && mode == 2'b00 && !prog_en) |=> !busy); // R10

endmodule

bind flash_seg_ctrl flash_seg_chk i_chk (
   .clk(clk), .puc(puc), .bus_req(bus_req), .bus_we(bus_we),
   .is_ctrl(is_ctrl), .is_arr(is_arr), .mode(mode_q), .prog_en(prog_q),
   .bus_rdata(bus_rdata), .busy(busy), .acc_viol(acc_viol)
);

// File: tb/test_flash_seg_ctrl.sv
`timescale 1ns/1ps
module test_flash_seg_ctrl;

   localparam int ER = 5, PR = 3, DIV = 2;
   localparam logic [15:0] CTRL = 16'h0128;

   logic        clk = 1'b0;
   logic        puc = 1'b1;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic [7:0]  bus_wdata = 8'h00;
   logic [15:0] bus_rdata;
   logic        busy, acc_viol;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   flash_seg_ctrl #(.CLK_DIV(DIV), .ERASE_CYCLES(ER), .PROG_CYCLES(PR)) i_flash_seg_ctrl (
      .clk(clk), .puc(puc), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .acc_viol(acc_viol)
   );

   // reference model state
   logic [7:0] mm [int];
   bit         m_busy, m_prog, m_av, m_op_prog;
   logic [1:0] m_mode;
   int         m_left;
   int         m_lo [$];
   int         m_hi [$];
   int         m_pa;
   logic [7:0] m_pd;

   function automatic bit in_arr(input logic [15:0] a);
      return (a >= 16'hF000) || (a >= 16'h1000 && a <= 16'h10FF);
   endfunction

   always @(posedge clk) begin
      bit b0;
      int a;
      if (puc) begin
         m_busy = 0; m_mode = 2'b00; m_prog = 0; m_av = 0; m_op_prog = 0;
         m_lo.delete(); m_hi.delete();
      end else begin
         b0 = m_busy;
         if (b0) begin
            if (m_left == 1) begin
               if (m_op_prog) begin
                  if (mm.exists(m_pa)) mm[m_pa] = mm[m_pa] & m_pd;
               end else begin
                  foreach (m_lo[k]) for (int i = m_lo[k]; i <= m_hi[k]; i++) mm[i] = 8'hFF;
                  m_mode = 2'b00;
               end
               m_busy = 0;
            end else m_left--;
         end
         if (bus_req && bus_we) begin
            a = int'(bus_addr);
            if (bus_addr == CTRL) begin
               if (b0) m_av = 1;
               else begin
                  m_mode = bus_wdata[1:0]; m_prog = bus_wdata[2]; m_av = m_av & bus_wdata[3];
               end
            end else if (in_arr(bus_addr) && !b0) begin
               if (m_mode != 2'b00) begin
                  m_lo.delete(); m_hi.delete();
                  if (m_mode == 2'b01) begin
                     if (a >= 'hF000) begin m_lo.push_back(a & 'hFE00); m_hi.push_back((a & 'hFE00) + 511); end
                     else begin m_lo.push_back(a & 'hFF80); m_hi.push_back((a & 'hFF80) + 127); end
                  end else begin
                     m_lo.push_back('hF000); m_hi.push_back('hFFFF);
                     if (m_mode == 2'b11) begin m_lo.push_back('h1000); m_hi.push_back('h10FF); end
                  end
                  m_op_prog = 0; m_busy = 1; m_left = ER * DIV;
               end else if (m_prog) begin
                  m_op_prog = 1; m_pa = a; m_pd = bus_wdata; m_busy = 1; m_left = PR * DIV;
               end
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      int a;
      #2;
      if (!puc) begin
         chk("R7 busy vs model", {15'b0, busy}, {15'b0, m_busy});
         chk("R9 violation vs model", {15'b0, acc_viol}, {15'b0, m_av});
         if (bus_req && !bus_we) begin
            a = int'(bus_addr);
            if (bus_addr == CTRL) chk("R2 ctrl read vs model", bus_rdata, {12'h000, m_av, m_prog, m_mode});
            else if (in_arr(bus_addr)) begin
               if (m_busy) chk("R8 busy read vs model", bus_rdata, 16'h3FFF);
               else if (mm.exists(a | 1) && mm.exists(a & ~1))
                  chk("R3 array read vs model", bus_rdata, {mm[a | 1], mm[a & ~1]});
            end else chk("R2 unmapped read vs model", bus_rdata, 16'h0000);
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_addr = a;
      #1 chk(tag, bus_rdata, exp);
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      bus_req = 0;
   endtask

   task automatic op(input logic [15:0] a, input logic [7:0] d);
      int n;
      wr(a, d);
      wait_idle(n);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      #2 chk("R1 busy after reset", {15'b0, busy}, 16'h0);
      chk("R1 violation after reset", {15'b0, acc_viol}, 16'h0);
      puc = 0;
      rd(CTRL, 16'h0000, "R1 ctrl after reset");

      // full erase to known content, with duration check
      wr(CTRL, 8'h03);
      wr(16'hF000, 8'h00);
      wait_idle(n);
      chk("R7 erase busy length", 16'(n), 16'(ER * DIV));
      rd(CTRL, 16'h0000, "R7 mode cleared after erase");
      rd(16'h1000, 16'hFFFF, "R5 full erase info");
      rd(16'hFFFE, 16'hFFFF, "R5 full erase main top");

      // programming
      wr(CTRL, 8'h04);
      wr(16'hFE00, 8'h12);
      wait_idle(n);
      chk("R7 program busy length", 16'(n), 16'(PR * DIV));
      op(16'hFE01, 8'h34);
      op(16'hF000, 8'hA5);
      op(16'h1000, 8'h5A);
      op(16'h1080, 8'h0F);
      op(16'hF200, 8'h77);
      rd(16'hFE00, 16'h3412, "R3 little-endian word");
      op(16'hFE00, 8'hF0);
      rd(16'hFE00, 16'h3410, "R6 program ANDs old and new");

      // activity while busy
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_addr = 16'hFE01; bus_wdata = 8'h0F;
      @(negedge clk);
      bus_we = 0; bus_addr = 16'hFE00;
      #1 chk("R8 read while busy", bus_rdata, 16'h3FFF);
      @(negedge clk);
      bus_we = 1; bus_addr = CTRL; bus_wdata = 8'h01;
      @(negedge clk);
      bus_addr = 16'hF000; bus_wdata = 8'h00;
      @(negedge clk);
      bus_we = 0; bus_addr = CTRL;
      #1 chk("R9 ctrl kept, violation set", bus_rdata, 16'h000C);
      wait_idle(n);
      rd(16'hFE00, 16'h0410, "R6 program after busy writes");
      rd(16'hF000, 16'hFFA5, "R10 array write while busy ignored");
      wr(CTRL, 8'h0C);
      rd(CTRL, 16'h000C, "R9 violation sticky on bit3=1");
      wr(CTRL, 8'h04);
      rd(CTRL, 16'h0004, "R9 violation cleared");

      // single segment erases
      wr(CTRL, 8'h01);
      op(16'hFE10, 8'h00);
      rd(16'hFE00, 16'hFFFF, "R4 segment 0 erased");
      rd(16'hF000, 16'hFFA5, "R4 segment 7 untouched");
      rd(16'hF200, 16'hFF77, "R4 segment 6 untouched");
      wr(CTRL, 8'h01);
      op(16'h1090, 8'h00);
      rd(16'h1080, 16'hFFFF, "R4 info A erased");
      rd(16'h1000, 16'hFF5A, "R4 info B untouched");

      // main group erase
      wr(CTRL, 8'h02);
      op(16'hF400, 8'h00);
      rd(16'hF000, 16'hFFFF, "R5 group erase seg7");
      rd(16'hF200, 16'hFFFF, "R5 group erase seg6");
      rd(16'h1000, 16'hFF5A, "R5 group erase spares info");

      // full erase through an info address
      wr(CTRL, 8'h03);
      op(16'h1000, 8'h00);
      rd(16'h1000, 16'hFFFF, "R5 full erase via info address");

      // write with nothing armed
      wr(CTRL, 8'h00);
      wr(16'hF000, 8'h00);
      #2 chk("R10 no start when unarmed", {15'b0, busy}, 16'h0);
      rd(16'hF000, 16'hFFFF, "R10 content unchanged when unarmed");

      // decode edges
      rd(16'h2000, 16'h0000, "R2 unmapped read");
      wr(CTRL, 8'h04);
      op(16'h10FF, 8'h3C);
      op(16'hF1FF, 8'h11);
      rd(16'h10FE, 16'h3CFF, "R2 top info byte");
      wr(CTRL, 8'h01);
      op(16'hF000, 8'h00);
      rd(16'hF1FE, 16'hFFFF, "R2 segment 7 upper edge erased");
      rd(16'h10FE, 16'h3CFF, "R4 info unaffected by seg7 erase");

      // reset during an operation
      wr(CTRL, 8'h04);
      wr(16'hF1FE, 8'h00);
      @(negedge clk);
      puc = 1;
      @(negedge clk);
      puc = 0;
      #2 chk("R11 busy cleared by reset", {15'b0, busy}, 16'h0);
      rd(CTRL, 16'h0000, "R1 ctrl cleared by reset");
      rd(16'hF1FE, 16'hFFFF, "R11 aborted program left content");
      repeat (PR * DIV + 2) @(negedge clk);
      rd(16'hF1FE, 16'hFFFF, "R11 no late program");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule